// File: doc/BRIEF.md
# Host Controller Byte Queues with Watermark Interrupt

This block holds the transmit and receive byte queues of a serial host controller, as software sees them through a small word-addressed register port. Software writes outgoing bytes into one data register and takes incoming bytes from another. The queue status travels in the top bit of the same word, so a single access both polls the queue and moves the data. On its far side the block gives a shift engine a pop port for outgoing bytes and a push port for incoming bytes.

Two programmable thresholds turn queue occupancy into level-sensitive pending conditions. The transmit condition means "running low" and the receive condition means "enough has arrived". An enable register masks the two conditions into one registered interrupt line. The pending bits are not latched events: each follows its occupancy comparison and clears only when that comparison stops holding.

Register word addresses: 0 transmit data, 1 receive data, 2 transmit threshold, 3 receive threshold, 4 interrupt enable, 5 pending. All register reads are registered, and the read word is on `reg_rdata` after the clock edge that samples `reg_rd`.

Top module: `spi_qbuf_top`

## Requirements
- R1: A write to address 0 enqueues `reg_wdata[7:0]` into the transmit queue, which holds DEPTH (default 8) bytes. The bytes appear on `tx_data` in write order while `tx_valid` is high, and each `tx_ready` cycle removes one.
- R2: A read of address 0 returns bit 31 = 1 when the transmit queue holds DEPTH bytes and 0 otherwise, with bits [30:0] zero.
- R3: A read of address 1 on an empty receive queue returns exactly 0x8000_0000 and removes nothing. Otherwise it returns the oldest received byte in bits [7:0], with bit 31 = 0, and removes that byte.
- R4: Pending bit 0 (address 5) is 1 exactly while transmit occupancy is strictly less than the transmit threshold (address 2).
- R5: Pending bit 1 (address 5) is 1 exactly while receive occupancy is strictly greater than the receive threshold (address 3).
- R6: A write to address 0 while the transmit queue is full is discarded and leaves the queue contents unchanged.
- R7: A push on `rx_valid` while the receive queue is full (`rx_full` = 1) is discarded.
- R8: The enable register (address 4, bit 0 transmit, bit 1 receive) resets to 0. `irq` is the OR of the enabled pending bits, taken one clock later through a register.
- R9: Writes to the pending register (address 5) have no effect on its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_data | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Engine takes one transmit byte |
| rx_valid | input | 1 | Engine pushes one received byte |
| rx_data | input | 8 | Received byte |
| rx_full | output | 1 | Receive queue full |
| irq | output | 1 | Registered watermark interrupt |

## Verification
A register write takes effect at the edge that samples it. A read word is valid after that same edge. Pending bits follow occupancy in the same cycle, and `irq` lags them by exactly one edge. The bench drives every strobe at a falling edge and samples results at the next falling edge, so each register result is checked one edge after its stimulus. For `irq`, the bench takes two samples: one at the falling edge right after the enabling write, where the line must still be low, and one a cycle later, where it must be high. A monitor process removes transmit bytes only when `tx_valid` is high and compares each one against the scoreboard queue at the falling edge before the edge that removes it.

// File: rtl/spi_qbuf_pkg.sv
package spi_qbuf_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int FLAG_POS = WORD_W - 1;

    typedef enum logic [ADDR_W-1:0] {
        ADR_TXDATA  = 3'd0,
        ADR_RXDATA  = 3'd1,
        ADR_TXMARK  = 3'd2,
        ADR_RXMARK  = 3'd3,
        ADR_IRQEN   = 3'd4,
        ADR_IRQPEND = 3'd5
    } reg_addr_e;

    // bit 0: transmit low-water, bit 1: receive high-water
    typedef struct packed {
        logic rx_wm;
        logic tx_wm;
    } wm_bits_t;

    function automatic logic [WORD_W-1:0] flag_word(input logic flag,
                                                    input logic [WORD_W-2:0] payload);
        return {flag, payload};
    endfunction

endpackage

// File: rtl/spi_qbuf_fifo.sv
module spi_qbuf_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [CNT_W-1:0] count_q;
    logic             do_push, do_pop;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] idx);
        return (idx == IDX_W'(DEPTH - 1)) ? '0 : idx + IDX_W'(1);
    endfunction

    assign full    = (count_q == CNT_W'(DEPTH));
    assign empty   = (count_q == '0);
    assign do_push = push_req && !full;
    assign do_pop  = pop_req && !empty;
    assign head    = mem[rd_idx];
    assign count   = count_q;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_idx] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx  <= '0;
            rd_idx  <= '0;
            count_q <= '0;
        end else begin
            if (do_push) wr_idx <= step(wr_idx);
            if (do_pop)  rd_idx <= step(rd_idx);
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    // R6 (transmit) and R7 (receive): a push into a full queue is lost
    a_r6_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
        full && push_req && !pop_req |=> $stable(count_q) && $stable(wr_idx));

    // R3: removing from an empty queue moves nothing
    a_r3_empty_pop_ignored: assert property (@(posedge clk) disable iff (rst)
        empty && pop_req |=> $stable(rd_idx));

    // R1: occupancy never exceeds the depth
    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/spi_qbuf_irq.sv
module spi_qbuf_irq
    import spi_qbuf_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_mark,
    input  logic [CNT_W-1:0] rx_mark,
    input  wm_bits_t         irq_en,
    output wm_bits_t         pend,
    output logic             irq
);

    logic irq_q;

    always_comb begin
        pend.tx_wm = (tx_count < tx_mark);
        pend.rx_wm = (rx_count > rx_mark);
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= (pend.tx_wm && irq_en.tx_wm) || (pend.rx_wm && irq_en.rx_wm);
    end

    assign irq = irq_q;

    // R8: with both enables clear, the line is low one edge later
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        irq_en == '0 |=> !irq);

    // R5: an empty receive queue can never be above any threshold
    a_r5_empty_no_rx_pend: assert property (@(posedge clk) disable iff (rst)
        rx_count == '0 |-> !pend.rx_wm);

endmodule

// File: rtl/spi_qbuf_top.sv
module spi_qbuf_top
    import spi_qbuf_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = BYTE_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              irq
);

    reg_addr_e         addr;
    logic [CNT_W-1:0]  tx_mark_q, rx_mark_q, tx_count, rx_count;
    wm_bits_t          ie_q, pend;
    logic              tx_full, tx_empty, rx_empty;
    logic              tx_push, rx_pop;
    logic [DATA_W-1:0] rx_head;
    logic [WORD_W-1:0] rd_mux, rdata_q;
    logic              unused_wdata;

    assign addr         = reg_addr_e'(reg_addr);
    assign tx_push      = reg_wr && (addr == ADR_TXDATA);
    assign rx_pop       = reg_rd && (addr == ADR_RXDATA);
    assign unused_wdata = ^reg_wdata;

    spi_qbuf_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_txq (
        .clk(clk), .rst(rst),
        .push_req(tx_push), .push_data(reg_wdata[DATA_W-1:0]),
        .pop_req(tx_ready), .head(tx_data),
        .full(tx_full), .empty(tx_empty), .count(tx_count)
    );

    spi_qbuf_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_rxq (
        .clk(clk), .rst(rst),
        .push_req(rx_valid), .push_data(rx_data),
        .pop_req(rx_pop), .head(rx_head),
        .full(rx_full), .empty(rx_empty), .count(rx_count)
    );

    spi_qbuf_irq #(.CNT_W(CNT_W)) u_irq (
        .clk(clk), .rst(rst),
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_mark(tx_mark_q), .rx_mark(rx_mark_q),
        .irq_en(ie_q), .pend(pend), .irq(irq)
    );

    assign tx_valid = !tx_empty;

    // configuration writes; the pending register has no write path (R9)
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_mark_q <= '0;
            rx_mark_q <= '0;
            ie_q      <= '0;
        end else if (reg_wr) begin
            case (addr)
                ADR_TXMARK: tx_mark_q <= reg_wdata[CNT_W-1:0];
                ADR_RXMARK: rx_mark_q <= reg_wdata[CNT_W-1:0];
                ADR_IRQEN:  ie_q      <= wm_bits_t'(reg_wdata[1:0]);
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            ADR_TXDATA:  rd_mux = flag_word(tx_full, '0);
            ADR_RXDATA:  rd_mux = flag_word(rx_empty, rx_empty ? '0 : (WORD_W-1)'(rx_head));
            ADR_TXMARK:  rd_mux = WORD_W'(tx_mark_q);
            ADR_RXMARK:  rd_mux = WORD_W'(rx_mark_q);
            ADR_IRQEN:   rd_mux = WORD_W'(ie_q);
            ADR_IRQPEND: rd_mux = WORD_W'(pend);
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;

    // R8: enables come out of reset cleared and the line is low
    a_r8_reset_state: assert property (@(posedge clk)
        rst |=> (ie_q == '0) && !irq);

    // R2: full status on a transmit read matches the queue state at the read edge
    a_r2_full_flag: assert property (@(posedge clk) disable iff (rst)
        reg_rd && addr == ADR_TXDATA |=> reg_rdata[FLAG_POS] == $past(tx_count == CNT_W'(DEPTH)));

    // R9: a write to the pending register leaves the enables untouched
    a_r9_pend_write_inert: assert property (@(posedge clk) disable iff (rst)
        reg_wr && addr == ADR_IRQPEND |=> $stable(ie_q) && $stable(tx_mark_q) && $stable(rx_mark_q));

endmodule

// File: tb/spi_qbuf_top_test.sv
`timescale 1ns/1ps
module spi_qbuf_top_test;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_valid, tx_ready, rx_valid = 1'b0, rx_full, irq;
    logic [7:0]  tx_data, rx_data = '0;

    int tests = 0, fails = 0;
    bit drain_en = 1'b0;
    logic [7:0] tx_exp[$];
    logic [7:0] rx_exp[$];

    always #4 clk = ~clk;

    spi_qbuf_top #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_full(rx_full), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    // driver: host write into the transmit queue, scoreboard updated by the model
    task automatic host_send(input logic [7:0] b);
        if (tx_exp.size() < DEPTH) tx_exp.push_back(b);
        reg_write(3'd0, {24'h0, b});
    endtask

    task automatic engine_push(input logic [7:0] b);
        @(negedge clk);
        if (rx_exp.size() < DEPTH) rx_exp.push_back(b);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // monitor: takes transmit bytes as the design offers them and scores them
    initial begin
        tx_ready = 1'b0;
        forever begin
            @(negedge clk);
            tx_ready = 1'b0;
            if (drain_en && tx_valid) begin
                if (tx_exp.size() == 0) check("R1 unexpected byte", {24'h0, tx_data}, 32'hxx);
                else check("R1 byte order", {24'h0, tx_data}, {24'h0, tx_exp.pop_front()});
                tx_ready = 1'b1;
            end
        end
    end

    task automatic drain_tx();
        drain_en = 1'b1;
        repeat (2 * DEPTH + 4) @(negedge clk);
        drain_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        check("R8 irq at reset", {31'h0, irq}, 32'h0);
        check("R1 tx_valid at reset", {31'h0, tx_valid}, 32'h0);
        reg_read(3'd4, d); check("R8 enable reset", d, 32'h0);
        reg_read(3'd0, d); check("R2 not full", d, 32'h0);
        reg_read(3'd1, d); check("R3 empty read", d, 32'h8000_0000);

        // fill the transmit queue, then one write too many
        for (int i = 0; i < DEPTH; i++) host_send(8'h10 + 8'(i));
        reg_read(3'd0, d); check("R2 full flag", d, 32'h8000_0000);
        host_send(8'hEE);
        drain_tx();
        check("R6 overflow byte dropped", {31'h0, tx_valid}, 32'h0);
        check("R6 scoreboard empty", tx_exp.size(), 32'h0);

        // receive: empty read removed nothing, so the next byte comes back
        engine_push(8'hA5);
        reg_read(3'd1, d); check("R3 first byte after empty read", d, {24'h0, rx_exp.pop_front()});
        for (int i = 0; i < DEPTH + 1; i++) engine_push(8'h40 + 8'(i));
        check("R7 rx_full", {31'h0, rx_full}, 32'h1);
        for (int i = 0; i < DEPTH; i++) begin
            reg_read(3'd1, d); check("R3 receive data", d, {24'h0, rx_exp.pop_front()});
        end
        reg_read(3'd1, d); check("R7 overflow push dropped", d, 32'h8000_0000);

        // transmit low-water boundary, threshold 3
        reg_write(3'd2, 32'd3);
        host_send(8'h01); host_send(8'h02);
        reg_read(3'd5, d); check("R4 occupancy 2 below 3", d, 32'h1);
        host_send(8'h03);
        reg_read(3'd5, d); check("R4 occupancy 3 not below 3", d, 32'h0);
        drain_tx();
        reg_read(3'd5, d); check("R4 empty below 3", d, 32'h1);

        // irq lags enabled pending by one edge
        reg_write(3'd4, 32'h1);
        check("R8 irq still low at write edge", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check("R8 irq one edge later", {31'h0, irq}, 32'h1);
        reg_write(3'd4, 32'h0);
        @(negedge clk);
        check("R8 masked irq", {31'h0, irq}, 32'h0);
        reg_write(3'd2, 32'd0);

        // receive high-water boundary, threshold 2
        reg_write(3'd3, 32'd2);
        engine_push(8'h71); engine_push(8'h72);
        reg_read(3'd5, d); check("R5 occupancy 2 not above 2", d, 32'h0);
        engine_push(8'h73);
        reg_read(3'd5, d); check("R5 occupancy 3 above 2", d, 32'h2);
        reg_write(3'd5, 32'h0);
        reg_read(3'd5, d); check("R9 pending write ignored", d, 32'h2);
        reg_write(3'd4, 32'h2);
        @(negedge clk);
        check("R8 rx irq", {31'h0, irq}, 32'h1);
        reg_read(3'd1, d); check("R3 rx byte", d, {24'h0, rx_exp.pop_front()});
        @(negedge clk);
        check("R5 irq clears with occupancy", {31'h0, irq}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule